// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave (1 Kbit, x8/x16)

This block models a small serial EEPROM that answers a three-wire command interface: a chip select, a serial clock, a data input and a data output. The slave holds 1 Kbit of storage. An organisation input chooses how that storage is seen: 64 words of 16 bits or 128 bytes of 8 bits. A host raises chip select and then clocks in a start bit, a 2-bit opcode and an address. For the program commands it then clocks in data. The slave decodes the frame and streams read data back. For a program command it starts a timed programming period once chip select falls.

All pins are sampled by the system clock through a synchroniser. The serial clock must therefore stay low and high for several system clocks each. Programming is modelled as a busy period of a parameterised length, followed by the array update. While that period runs, the data output doubles as a ready/busy flag. A write-enable latch guards every command that changes the array. Reset clears the latch.

Top module: `mw_eeprom`

## Requirements
- R1: After reset the write-enable latch is clear, no programming is running and the data output is 0.
- R2: A frame begins with the first data-input 1 sampled on a serial-clock rising edge while select is high; zeros before it are ignored. Then follow a 2-bit opcode and the address, MSB first: 6 bits when the organisation input is 1 (x16), 7 bits when it is 0 (x8).
- R3: Opcode 10 reads. On the rising edge that takes the last address bit the output becomes 0. Each further rising edge then presents the next data bit, MSB first, 16 bits in x16 mode and 8 bits in x8 mode. Byte b is the low half of word b/2 when b is even and the high half when b is odd.
- R4: While select stays high, the read continues with the next location and no 0 is inserted between words. The address wraps from word 63 (or byte 127) to location 0.
- R5: Opcode 01 writes. It takes 16 (x16) or 8 (x8) data bits, MSB first, after the address, and stores them at the addressed location. An x8 write leaves the other half of its word unchanged.
- R6: Opcode 11 erases the addressed location to all ones.
- R7: Opcode 00 with address top bits 11 sets the write-enable latch, and with top bits 00 clears it. The other address bits are don't-care, and the latch holds its value until the next such command or a reset.
- R8: While the latch is clear, write, erase, erase-all and write-all change nothing and start no busy period. Read works whatever the latch holds.
- R9: Opcode 00 with top bits 10 erases every location to all ones. With top bits 01 it writes the following data to every location; an x8 data byte fills both halves of every word.
- R10: Programming starts only when select falls after a complete program frame. A frame cut short by select falling starts nothing.
- R11: During programming the output is 0 whenever select is high, and it reads 1 once programming is done. The busy period lasts at least PROG_CYCLES clocks, and frames sent during it are ignored.
- R12: The data output is 0 while select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data input |
| org_wide_i | input | 1 | Organisation: 1 selects 64x16, 0 selects 128x8 |
| sdo_o | output | 1 | Serial data output and ready/busy flag |

## Verification
A decoder that loses its bit count shows up at the output within one frame. The 0 placeholder lands on the wrong serial edge, or the read word comes out shifted by a bit. A bad read pointer shows up during the second word of a streamed read, and at the wrap from the last location. A write-enable latch or programming sequencer in the wrong state shows up as soon as select rises again after a program frame: the output reads 1 when it should be busy, or the other way round. A lane-select fault only shows when a read in the other organisation returns the neighbouring half unchanged or overwritten.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_DONE
  } dec_state_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] SUB_LOCK   = 2'b00;
  localparam logic [1:0] SUB_FILL   = 2'b01;
  localparam logic [1:0] SUB_CLRALL = 2'b10;
  localparam logic [1:0] SUB_UNLOCK = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         pipe[s] <= '0;
      else if (s == 0) pipe[s] <= d_i;
      else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int WORDS  = 64,
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int AW = $clog2(WORDS),
  localparam int DW = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [LANES-1:0] wbe,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [WORDS];
    logic [LANE_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we && wbe[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
      rd_q <= mem[raddr];
    end
    assign rdata[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/mw_prog.sv
module mw_prog #(
  parameter int WORDS       = 64,
  parameter int DW          = 16,
  parameter int LANES       = 2,
  parameter int PROG_CYCLES = 200,
  localparam int AW = $clog2(WORDS),
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             all,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic [LANES-1:0] be_i,
  output logic             busy,
  output logic             we,
  output logic [AW-1:0]    waddr,
  output logic [DW-1:0]    wdata,
  output logic [LANES-1:0] wbe
);
  typedef enum logic [1:0] {P_IDLE, P_WAIT, P_COMMIT} pst_t;

  pst_t             st;
  logic [CW-1:0]    tmr;
  logic [AW-1:0]    ptr;
  logic             all_q;
  logic [DW-1:0]    data_q;
  logic [LANES-1:0] be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= P_IDLE; tmr <= '0; ptr <= '0;
      all_q <= 1'b0; data_q <= '0; be_q <= '0;
    end else begin
      case (st)
        P_IDLE: if (start) begin
          st     <= P_WAIT;
          tmr    <= '0;
          all_q  <= all;
          ptr    <= all ? '0 : addr_i;
          data_q <= data_i;
          be_q   <= be_i;
        end
        P_WAIT: begin
          if (tmr == CW'(PROG_CYCLES - 1)) st <= P_COMMIT;
          else tmr <= tmr + 1'b1;
        end
        P_COMMIT: begin
          if (!all_q || ptr == AW'(WORDS - 1)) st <= P_IDLE;
          else ptr <= ptr + 1'b1;
        end
        default: st <= P_IDLE;
      endcase
    end
  end

  assign busy  = (st != P_IDLE);
  assign we    = (st == P_COMMIT);
  assign waddr = ptr;
  assign wdata = data_q;
  assign wbe   = be_q;

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);                                              // R11
  AST_COMMIT_HAS_LANE: assert property (@(posedge clk) disable iff (rst)
    we |-> wbe != '0);                                             // R5
  AST_SWEEP_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && $past(all_q)) |-> $past(ptr) == AW'(WORDS - 1)); // R9
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int WORDS16     = 64,
  parameter int PROG_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sel_i,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic org_wide_i,
  output logic sdo_o
);
  import mw_pkg::*;

  localparam int AW16 = $clog2(WORDS16);
  localparam int AW8  = AW16 + 1;
  localparam int DW   = 16;
  localparam int CNTW = 5;

  // pin synchroniser
  logic [3:0] pins_s;
  mw_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst),
    .d_i({org_wide_i, sdi_i, sck_i, sel_i}), .q_o(pins_s));

  logic sel_s, sck_s, sdi_s, wide_s;
  assign {wide_s, sdi_s, sck_s, sel_s} = pins_s;

  logic sel_p, sck_p;
  always_ff @(posedge clk) begin
    if (rst) begin sel_p <= 1'b0; sck_p <= 1'b0; end
    else begin sel_p <= sel_s; sck_p <= sck_s; end
  end
  logic sel_fall, sck_rise;
  assign sel_fall = sel_p & ~sel_s;
  assign sck_rise = sck_s & ~sck_p;

  // decoder state
  dec_state_t      state;
  logic [1:0]      op;
  logic [AW8-1:0]  addr_sr, rd_addr;
  logic [DW-1:0]   data_sr, sh;
  logic [CNTW-1:0] cnt;
  logic [3:0]      left;
  logic            wen, pend, pall, perase, sdo;
  logic            busy;

  logic [AW8-1:0]  addr_nx;
  logic [1:0]      sub;
  logic [CNTW-1:0] alast, dlast;
  logic [3:0]      wlast;
  assign addr_nx = {addr_sr[AW8-2:0], sdi_s};
  assign sub     = wide_s ? addr_nx[AW16-1 -: 2] : addr_nx[AW8-1 -: 2];
  assign alast   = wide_s ? CNTW'(AW16 - 1) : CNTW'(AW8 - 1);
  assign dlast   = wide_s ? CNTW'(15) : CNTW'(7);
  assign wlast   = wide_s ? 4'd15 : 4'd7;

  // read path: array port and lane pick
  logic [AW16-1:0] raddr;
  logic [DW-1:0]   rdata, load_word;
  logic [7:0]      lane_byte;
  logic [AW8-1:0]  rd_next;
  assign raddr     = wide_s ? rd_addr[AW16-1:0] : rd_addr[AW8-1:1];
  assign lane_byte = rd_addr[0] ? rdata[15:8] : rdata[7:0];
  assign load_word = wide_s ? rdata : {lane_byte, 8'h00};
  assign rd_next   = wide_s ? {1'b0, rd_addr[AW16-1:0] + 1'b1} : rd_addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; op <= '0; addr_sr <= '0; rd_addr <= '0;
      data_sr <= '0; sh <= '0; cnt <= '0; left <= '0;
      wen <= 1'b0; pend <= 1'b0; pall <= 1'b0; perase <= 1'b0; sdo <= 1'b0;
    end else if (!sel_s) begin
      state <= ST_IDLE;
      pend  <= 1'b0;
      sdo   <= 1'b0;
    end else if (busy) begin
      sdo <= 1'b0;
    end else begin
      if (state != ST_RD) sdo <= 1'b1;
      if (sck_rise) begin
        case (state)
          ST_IDLE: if (sdi_s) begin
            state <= ST_OPC;
            cnt   <= '0;
          end
          ST_OPC: begin
            op <= {op[0], sdi_s};
            if (cnt == CNTW'(1)) begin state <= ST_ADR; cnt <= '0; end
            else cnt <= cnt + 1'b1;
          end
          ST_ADR: begin
            addr_sr <= addr_nx;
            if (cnt == alast) begin
              cnt   <= '0;
              state <= ST_DONE;
              case (op)
                OP_READ: begin
                  state   <= ST_RD;
                  rd_addr <= wide_s ? {1'b0, addr_nx[AW16-1:0]} : addr_nx;
                  left    <= '0;
                  sdo     <= 1'b0;
                end
                OP_WRITE: begin
                  state <= ST_DAT; pall <= 1'b0; perase <= 1'b0;
                end
                OP_ERASE: begin
                  pend <= wen; pall <= 1'b0; perase <= 1'b1;
                end
                default: begin
                  case (sub)
                    SUB_UNLOCK: wen <= 1'b1;
                    SUB_LOCK:   wen <= 1'b0;
                    SUB_CLRALL: begin pend <= wen; pall <= 1'b1; perase <= 1'b1; end
                    default:    begin state <= ST_DAT; pall <= 1'b1; perase <= 1'b0; end
                  endcase
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DAT: begin
            data_sr <= {data_sr[DW-2:0], sdi_s};
            if (cnt == dlast) begin pend <= wen; state <= ST_DONE; end
            else cnt <= cnt + 1'b1;
          end
          ST_RD: begin
            if (left == 4'd0) begin
              sdo     <= load_word[DW-1];
              sh      <= {load_word[DW-2:0], 1'b0};
              left    <= wlast;
              rd_addr <= rd_next;
            end else begin
              sdo  <= sh[DW-1];
              sh   <= {sh[DW-2:0], 1'b0};
              left <= left - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_o = sdo;

  // programming sequencer and array
  logic            prog_start;
  logic [AW16-1:0] p_addr, m_waddr;
  logic [DW-1:0]   p_data, m_wdata;
  logic [1:0]      p_be, m_wbe;
  logic            m_we;
  assign prog_start = sel_fall & pend;
  assign p_addr = wide_s ? addr_sr[AW16-1:0] : addr_sr[AW8-1:1];
  assign p_data = perase ? '1 : (wide_s ? data_sr : {data_sr[7:0], data_sr[7:0]});
  assign p_be   = (pall || wide_s) ? 2'b11 : (addr_sr[0] ? 2'b10 : 2'b01);

  mw_prog #(.WORDS(WORDS16), .DW(DW), .LANES(2), .PROG_CYCLES(PROG_CYCLES)) i_prog (
    .clk(clk), .rst(rst), .start(prog_start), .all(pall),
    .addr_i(p_addr), .data_i(p_data), .be_i(p_be),
    .busy(busy), .we(m_we), .waddr(m_waddr), .wdata(m_wdata), .wbe(m_wbe));

  mw_array #(.WORDS(WORDS16), .LANES(2), .LANE_W(8)) i_array (
    .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata), .wbe(m_wbe),
    .raddr(raddr), .rdata(rdata));

  AST_WEN_CLEAR_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wen);                                          // R1
  AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> state == ST_IDLE);                                    // R11
  AST_PROG_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> wen);                                           // R8
  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD && $past(state) == ST_ADR) |-> !sdo_o);        // R3
  AST_Q_LOW_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    (!sel_s && !sel_p) |=> !sdo_o);                                // R12
endmodule

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int PROG = 200;
  localparam int H    = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic sel = 1'b0, sck = 1'b0, sdi = 1'b0, org = 1'b1;
  logic sdo;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m [128];
  bit mwen = 1'b0;

  always #10 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) i_mw_eeprom (
    .clk(clk), .rst(rst), .sel_i(sel), .sck_i(sck), .sdi_i(sdi),
    .org_wide_i(org), .sdo_o(sdo));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int alen(); return org ? 6 : 7; endfunction
  function automatic int dlen(); return org ? 16 : 8; endfunction
  function automatic int locs(); return org ? 64 : 128; endfunction
  function automatic logic [15:0] exp_word(input int i);
    return org ? {m[2*i+1], m[2*i]} : {8'h00, m[i]};
  endfunction

  task automatic bit_io(input logic b, output logic q);
    sdi = b; tick(H);
    sck = 1'b1; tick(H);
    q = sdo; sck = 1'b0;
  endtask

  task automatic sel_on();  sck = 1'b0; sel = 1'b1; tick(H); endtask
  task automatic sel_off(); sel = 1'b0; sdi = 1'b0; tick(H); endtask

  task automatic send_head(input logic [1:0] op, input int a, output logic q);
    bit_io(1'b1, q); bit_io(op[1], q); bit_io(op[0], q);
    for (int i = alen() - 1; i >= 0; i--) bit_io(a[i], q);
  endtask

  task automatic send_data(input logic [15:0] d, input int nbits);
    logic q;
    for (int i = nbits - 1; i >= 0; i--) bit_io(d[i], q);
  endtask

  // after a program frame: select low, then select high and observe ready/busy
  task automatic finish_prog(input string req);
    int c;
    bit expect_busy;
    expect_busy = mwen;
    sel_off();
    chk("R12 output low while deselected", {15'd0, sdo}, 16'd0);
    sel_on();
    if (expect_busy) begin
      chk("R11 busy reads 0", {15'd0, sdo}, 16'd0);
      c = 0;
      while (sdo !== 1'b1 && c < 5000) begin tick(1); c++; end
      chk("R11 ready after busy period", {15'd0, sdo}, 16'd1);
      chk("R11 busy length", {15'd0, (c + 2*H >= PROG)}, 16'd1);
    end else begin
      chk(req, {15'd0, sdo}, 16'd1);
    end
    sel_off();
  endtask

  task automatic do_read(input int a, input int n, input int lead, input string req);
    logic q;
    logic [15:0] got;
    sel_on();
    for (int i = 0; i < lead; i++) bit_io(1'b0, q);
    send_head(2'b10, a, q);
    chk("R3 placeholder zero", {15'd0, q}, 16'd0);
    for (int w = 0; w < n; w++) begin
      got = '0;
      for (int b = 0; b < dlen(); b++) begin bit_io(1'b0, q); got = {got[14:0], q}; end
      chk(w == 0 ? req : "R4 streamed word", got, exp_word((a + w) % locs()));
    end
    sel_off();
  endtask

  task automatic ext(input logic [1:0] sub);
    logic q;
    sel_on();
    send_head(2'b00, int'(sub) << (alen() - 2), q);
    sel_off();
    if (sub == 2'b11) mwen = 1'b1;
    if (sub == 2'b00) mwen = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input string req);
    logic q;
    sel_on(); send_head(2'b01, a, q); send_data(d, dlen());
    if (mwen) begin
      if (org) begin m[2*a] = d[7:0]; m[2*a+1] = d[15:8]; end
      else m[a] = d[7:0];
    end
    finish_prog(req);
  endtask

  task automatic do_erase(input int a);
    logic q;
    sel_on(); send_head(2'b11, a, q);
    if (mwen) begin
      if (org) begin m[2*a] = 8'hFF; m[2*a+1] = 8'hFF; end
      else m[a] = 8'hFF;
    end
    finish_prog("R8 erase ignored");
  endtask

  task automatic do_fill(input logic [15:0] d);
    logic q;
    sel_on(); send_head(2'b00, 1 << (alen() - 2), q); send_data(d, dlen());
    if (mwen) for (int i = 0; i < 64; i++) begin
      m[2*i]   = d[7:0];
      m[2*i+1] = org ? d[15:8] : d[7:0];
    end
    finish_prog("R8 write-all ignored");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic q;
    int c;
    tick(5); rst = 1'b0; tick(2);
    chk("R1 output after reset", {15'd0, sdo}, 16'd0);
    sel_on();
    chk("R1 not busy after reset", {15'd0, sdo}, 16'd1);
    sel_off();

    // R7 unlock, then R9 erase-all with a frame sent during busy (R11)
    ext(2'b11);
    sel_on(); send_head(2'b00, 2 << 4, q); sel_off();
    for (int i = 0; i < 128; i++) m[i] = 8'hFF;
    sel_on();
    chk("R11 busy after erase-all", {15'd0, sdo}, 16'd0);
    send_head(2'b00, 0, q);               // lock frame during busy: ignored
    sel_off();
    sel_on();
    c = 0;
    while (sdo !== 1'b1 && c < 5000) begin tick(1); c++; end
    chk("R11 ready after erase-all", {15'd0, sdo}, 16'd1);
    sel_off();
    do_read(0, 2, 0, "R9 erase-all contents");

    do_write(5, 16'hA5C3, "R5 write");
    do_read(5, 1, 0, "R5 write readback (still enabled, R11)");
    do_read(4, 3, 0, "R4 sequential start");
    do_write(63, 16'h1111, "R5 write last");
    do_read(63, 2, 0, "R4 wrap x16");

    org = 1'b0; tick(H);
    do_read(10, 2, 0, "R3 byte lane mapping");
    do_write(10, 16'h005A, "R5 byte write");
    do_erase(11);
    org = 1'b1; tick(H);
    do_read(5, 1, 0, "R6 erase byte keeps other half");
    org = 1'b0; tick(H);
    do_read(127, 2, 0, "R4 wrap x8");

    ext(2'b00);                            // R7 lock
    do_write(0, 16'h0000, "R8 write while locked starts no busy");
    do_read(0, 1, 0, "R8 read while locked");
    do_erase(1);
    do_read(1, 1, 0, "R8 erase while locked");

    org = 1'b1; tick(H);
    ext(2'b11);
    sel_on(); send_head(2'b01, 0, q); send_data(16'h00, 8); sel_off();
    sel_on();
    chk("R10 cut frame starts nothing", {15'd0, sdo}, 16'd1);
    sel_off();
    do_read(0, 1, 3, "R2 leading zeros and R10 contents kept");

    do_fill(16'h1357);
    do_read(0, 3, 0, "R9 write-all x16");
    org = 1'b0; tick(H);
    do_fill(16'h009C);
    org = 1'b1; tick(H);
    do_read(2, 1, 0, "R9 write-all x8 fills both halves");

    rst = 1'b1; tick(3); rst = 1'b0; tick(2);
    mwen = 1'b0;
    do_write(0, 16'h0000, "R1 reset clears enable (R7)");
    do_read(0, 1, 0, "R1 contents after reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule